// File: doc/BRIEF.md
# Pulse-Interval Reader Frame Decoder

This block recovers the bits of a reader-to-tag frame on a 125 kHz low-frequency link. The reader sends each bit by dropping its field briefly. The bit value is set by how long it takes until the next field drop. The block receives a field-gap signal from the analog front end, which rises whenever the field drops. It also receives a one-clock tick for every carrier period (T0, 8 µs). It measures the time between successive rising edges of the gap signal in T0 units and sorts each measurement into one of four classes: a one, a zero, a long delimiter gap, or noise.

Decoded bits are packed first-bit-most-significant into a buffer of up to 20 bytes. A long delimiter gap adds no bit. Instead, it records the reader response time, which is the gap length minus the low phase. When the link has been silent long enough, the frame is closed. A frame that holds any bits is then delivered, with its bit count, in a one-clock strobe, and the buffer is emptied for the next frame.

Top module: `pulse_frame_decoder`

## Requirements
- R1: After reset, `frame_valid_o`, `frame_bits_o`, `frame_data_o` and `resp_time_o` are all zero.
- R2: An interval of 36 T0 or more between rising edges adds no bit, and `resp_time_o` becomes that interval minus 8. It holds that value until the next such gap.
- R3: An interval of 25 to 35 T0 appends a one.
- R4: An interval of 15 to 24 T0 appends a zero.
- R5: An interval under 15 T0 is treated as noise and appends nothing. The next interval is still measured from this noise edge.
- R6: Bit n of a frame is stored at `frame_data_o[8*(n/8) + 7 - (n%8)]`, which is byte n/8, bit 7-(n mod 8). `frame_bits_o` holds the number of bits stored so far.
- R7: If 80 T0 ticks pass without a rising edge, the frame is closed and `frame_valid_o` is high for exactly one clock, with the frame contents on the data and count outputs. An interval of up to 79 T0 keeps the current frame open.
- R8: In the clock after `frame_valid_o`, `frame_bits_o` and `frame_data_o` are zero.
- R9: A frame that closes with no bits produces no `frame_valid_o`.
- R10: The interval counter saturates at 255 T0 and does not wrap, so a very long silence reports a response time of 247.
- R11: Only the rising edge of `gap_i` matters. The length of the high phase does not change the decoded bit.
- R12: Bits beyond 160 in one frame are discarded, and `frame_bits_o` stays at 160.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gap_i | input | 1 | Asynchronous field-gap indication, rises at each field drop |
| tick_i | input | 1 | One-clock pulse per carrier period (T0) |
| frame_valid_o | output | 1 | One-clock strobe when a non-empty frame closes |
| frame_bits_o | output | 8 | Number of bits held in the buffer |
| frame_data_o | output | 160 | Frame buffer, byte k at [8k+7:8k], first bit in bit 7 |
| resp_time_o | output | 8 | Most recent delimiter gap minus 8 T0 |

## Verification
The hardest cases to reach are the interval boundaries: 14/15, 24/25, 35/36 and 79/80 T0. Each class decision can slip by one count if a field-gap edge lands in the same clock as a tick. The stimulus therefore changes `gap_i` only in the clock just after a tick. This keeps a constant number of ticks between the rising edges the design sees, so every interval is exact. Saturation is reached with a 400 T0 silence before a frame. The buffer limit is reached with a 170-bit frame.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    SYM_NOISE,
    SYM_ZERO,
    SYM_ONE,
    SYM_GAP
  } sym_e;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], sig_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  a_r11_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pfd_interval_timer.sv
module pfd_interval_timer #(
  parameter int CNT_W  = 8,
  parameter int EOF_T0 = 80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] interval_o,
  output logic             eof_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] EOF_PRE = CNT_W'(EOF_T0 - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (rise_i)                     cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign interval_o = cnt_q;
  // fires once per silence: the tick that takes the count to EOF_T0
  assign eof_o = tick_i & ~rise_i & (cnt_q == EOF_PRE);

  a_r10_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !rise_i) |=> cnt_q == CNT_MAX);
  a_r7_eof_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o);
endmodule

// File: rtl/pfd_bit_packer.sv
module pfd_bit_packer #(
  parameter int MAX_BITS = 160,
  parameter int BITS_W   = $clog2(MAX_BITS + 1),
  parameter int DATA_W   = 8 * ((MAX_BITS + 7) / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              bit_i,
  input  logic              clear_i,
  output logic [DATA_W-1:0] data_o,
  output logic [BITS_W-1:0] bits_o
);
  localparam logic [BITS_W-1:0] BITS_CAP = BITS_W'(MAX_BITS);

  logic [DATA_W-1:0] buf_q;
  logic [BITS_W-1:0] bits_q;
  logic [BITS_W-1:0] wr_idx;

  // byte = count/8, bit within byte = 7 - count%8
  assign wr_idx = {bits_q[BITS_W-1:3], ~bits_q[2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      bits_q <= '0;
    end else if (clear_i) begin
      buf_q  <= '0;
      bits_q <= '0;
    end else if (push_i && bits_q != BITS_CAP) begin
      buf_q[wr_idx] <= bit_i;
      bits_q        <= bits_q + 1'b1;
    end
  end

  assign data_o = buf_q;
  assign bits_o = bits_q;

  a_r12_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bits_q <= BITS_CAP);
  a_r12_hold_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bits_q == BITS_CAP && !clear_i) |=> bits_q == BITS_CAP);
endmodule

// File: rtl/pulse_frame_decoder.sv
module pulse_frame_decoder
  import pfd_pkg::*;
#(
  parameter int MAX_BITS    = 160,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ZERO_MIN_T0 = 15,
  parameter int ONE_MIN_T0  = 25,
  parameter int GAP_MIN_T0  = 36,
  parameter int LOW_T0      = 8,
  parameter int EOF_T0      = 80,
  parameter int BITS_W      = $clog2(MAX_BITS + 1),
  parameter int DATA_W      = 8 * ((MAX_BITS + 7) / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gap_i,
  input  logic              tick_i,
  output logic              frame_valid_o,
  output logic [BITS_W-1:0] frame_bits_o,
  output logic [DATA_W-1:0] frame_data_o,
  output logic [CNT_W-1:0]  resp_time_o
);
  localparam logic [CNT_W-1:0] ZERO_C = CNT_W'(ZERO_MIN_T0);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(ONE_MIN_T0);
  localparam logic [CNT_W-1:0] GAP_C  = CNT_W'(GAP_MIN_T0);
  localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(LOW_T0);

  logic             rise;
  logic             eof;
  logic [CNT_W-1:0] interval;
  sym_e             sym;
  logic             push;
  logic             valid_q;
  logic [CNT_W-1:0] resp_q;

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (gap_i),
    .rise_o(rise)
  );

  pfd_interval_timer #(.CNT_W(CNT_W), .EOF_T0(EOF_T0)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rise_i    (rise),
    .interval_o(interval),
    .eof_o     (eof)
  );

  always_comb begin
    if (interval >= GAP_C)       sym = SYM_GAP;
    else if (interval >= ONE_C)  sym = SYM_ONE;
    else if (interval >= ZERO_C) sym = SYM_ZERO;
    else                         sym = SYM_NOISE;
  end

  assign push = rise & (sym == SYM_ONE || sym == SYM_ZERO);

  pfd_bit_packer #(.MAX_BITS(MAX_BITS), .BITS_W(BITS_W), .DATA_W(DATA_W)) u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .bit_i  (sym == SYM_ONE),
    .clear_i(valid_q),
    .data_o (frame_data_o),
    .bits_o (frame_bits_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      resp_q  <= '0;
    end else begin
      valid_q <= eof & (frame_bits_o != '0);
      if (rise && sym == SYM_GAP) resp_q <= interval - LOW_C;
    end
  end

  assign frame_valid_o = valid_q;
  assign resp_time_o   = resp_q;

  a_r7_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o);
  a_r8_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> (frame_bits_o == '0 && frame_data_o == '0));
  a_r9_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> frame_bits_o != '0);
  a_r2_resp_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(resp_time_o));
endmodule

// File: tb/tb_pulse_frame_decoder.sv
`timescale 1ns/1ps
module tb_pulse_frame_decoder;
  localparam int MAXB = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gap_i = 1'b0;
  logic tick_i = 1'b0;
  logic frame_valid_o;
  logic [7:0] frame_bits_o;
  logic [MAXB-1:0] frame_data_o;
  logic [7:0] resp_time_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pulse_frame_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .gap_i(gap_i), .tick_i(tick_i),
    .frame_valid_o(frame_valid_o), .frame_bits_o(frame_bits_o),
    .frame_data_o(frame_data_o), .resp_time_o(resp_time_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [MAXB-1:0] act, input logic [MAXB-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // tick generator: one tick every 4 clocks
  int ph = 0;
  always @(negedge clk) begin
    if (!rst_n) begin ph <= 0; tick_i <= 1'b0; end
    else begin ph <= (ph == 3) ? 0 : ph + 1; tick_i <= (ph == 3); end
  end

  // behavioural reference model
  bit h1, h2, h3;
  int m_cnt, m_bits, m_resp;
  bit m_valid;
  logic [MAXB-1:0] m_data;
  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = 0; h2 = 0; h3 = 0; m_cnt = 0; m_bits = 0; m_resp = 0; m_valid = 0; m_data = '0;
    end else begin
      bit rise, nv;
      int pre_bits;
      rise = h2 && !h3;
      pre_bits = m_bits;
      nv = 0;
      if (m_valid) begin m_bits = 0; m_data = '0; end
      if (rise) begin
        int iv;
        iv = m_cnt;
        if (iv >= 36) m_resp = iv - 8;
        else if (iv >= 15 && m_bits < MAXB) begin
          m_data[8*(m_bits/8) + 7 - (m_bits%8)] = (iv >= 25);
          m_bits++;
        end
        m_cnt = 0;
      end else if (tick_i) begin
        if (m_cnt == 79 && pre_bits > 0) nv = 1;
        if (m_cnt < 255) m_cnt++;
      end
      m_valid = nv;
      h3 = h2; h2 = h1; h1 = gap_i;
    end
  end

  // per-cycle comparison and frame capture
  int nvalid = 0;
  int cap_bits;
  logic [MAXB-1:0] cap_data;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(frame_valid_o == m_valid, "R7 cycle valid", MAXB'(frame_valid_o), MAXB'(m_valid));
      chk(frame_bits_o == m_bits, "R6 cycle count", MAXB'(frame_bits_o), MAXB'(m_bits));
      chk(frame_data_o == m_data, "R6 cycle data", frame_data_o, m_data);
      chk(resp_time_o == m_resp, "R2 cycle resp", MAXB'(resp_time_o), MAXB'(m_resp));
      if (frame_valid_o) begin
        nvalid++; cap_bits = frame_bits_o; cap_data = frame_data_o;
      end
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge clk iff tick_i);
    @(negedge clk);
  endtask

  task automatic send_bit(input int total, input int hi);
    gap_i = 1'b1; wait_ticks(hi);
    gap_i = 1'b0; wait_ticks(total - hi);
  endtask

  task automatic trail(input int idle);
    gap_i = 1'b1; wait_ticks(6);
    gap_i = 1'b0; wait_ticks(idle);
  endtask

  task automatic send_frame(input bit q[$]);
    foreach (q[i]) send_bit(q[i] ? 28 : 22, 6);
    trail(94);
  endtask

  function automatic logic [MAXB-1:0] pack(input bit q[$]);
    logic [MAXB-1:0] d = '0;
    for (int i = 0; i < q.size() && i < MAXB; i++) d[8*(i/8) + 7 - (i%8)] = q[i];
    return d;
  endfunction

  task automatic frame_chk(input string tag, input int exp_n, input bit q[$]);
    int eb;
    eb = (q.size() > MAXB) ? MAXB : q.size();
    chk(nvalid == exp_n, {tag, " frame count"}, MAXB'(nvalid), MAXB'(exp_n));
    chk(cap_bits == eb, {tag, " bit count"}, MAXB'(cap_bits), MAXB'(eb));
    chk(cap_data == pack(q), {tag, " data"}, cap_data, pack(q));
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    bit q[$];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(frame_valid_o == 0 && frame_bits_o == 0 && frame_data_o == '0 && resp_time_o == 0,
        "R1 reset state", frame_data_o | MAXB'(frame_bits_o), '0);
    wait_ticks(50);

    // R3 R4 R6 R7: 11000
    q = '{1, 1, 0, 0, 0};
    send_frame(q);
    frame_chk("R3 R4 R7 basic", 1, q);
    // R8
    chk(frame_bits_o == 0 && frame_data_o == '0, "R8 cleared", frame_data_o | MAXB'(frame_bits_o), '0);

    // R2: leading silence 100 T0 -> 92
    q = '{0, 1};
    send_frame(q);
    frame_chk("R6 two bits", 2, q);
    chk(resp_time_o == 92, "R2 response time", MAXB'(resp_time_o), MAXB'(92));

    // R3 R4 R5 boundaries: 15,14,24,25,35,36,22
    send_bit(15, 6); send_bit(14, 6); send_bit(24, 6); send_bit(25, 6);
    send_bit(35, 6); send_bit(36, 6); send_bit(22, 6); trail(94);
    q = '{0, 0, 1, 1, 0};
    frame_chk("R3 R4 R5 boundaries", 3, q);
    chk(resp_time_o == 28, "R2 in-frame gap", MAXB'(resp_time_o), MAXB'(28));

    // R7: 79 T0 gap keeps frame open
    send_bit(28, 6); send_bit(79, 6); send_bit(28, 6); send_bit(22, 6); trail(94);
    q = '{1, 1, 0};
    frame_chk("R7 gap 79", 4, q);
    chk(resp_time_o == 71, "R2 gap 79", MAXB'(resp_time_o), MAXB'(71));

    // R9 R5: noise-only frame delivers nothing
    send_bit(10, 6); trail(94);
    chk(nvalid == 4, "R9 empty frame", MAXB'(nvalid), MAXB'(4));
    chk(frame_bits_o == 0, "R5 noise adds no bit", MAXB'(frame_bits_o), '0);

    // R10: long silence saturates
    wait_ticks(300);
    q = '{1};
    send_frame(q);
    frame_chk("R10 after saturation", 5, q);
    chk(resp_time_o == 247, "R10 saturated response", MAXB'(resp_time_o), MAXB'(247));

    // R11: high width does not matter
    send_bit(28, 3); send_bit(22, 12); trail(94);
    q = '{1, 0};
    frame_chk("R11 pulse width", 6, q);

    // R12: 170 bits
    q = {};
    for (int i = 0; i < 170; i++) q.push_back(i % 3 == 0);
    send_frame(q);
    frame_chk("R12 overflow", 7, q);

    finish_run();
  end
endmodule